// File: doc/BRIEF.md
# Flash Write Strobe Qualifier

This block stands between the raw bus strobes of a parallel flash device and its command sequencer. It decides whether a falling and rising write-enable strobe counts as a real write cycle. A write is passed on only when three things hold. The write-enable low period was long enough not to be a glitch. Chip enable was low and output enable was high for the whole of that low period. The supply had been reported good for a full hold-off interval.

The three strobes are asynchronous to the system clock. Each passes through a two-flop synchroniser before its low time is measured in clock cycles. The supply-good flag comes from an external comparator and is taken as already synchronous to the clock. A hold-off machine (states OFF, COUNT, READY) times the power-on lockout. OFF moves to COUNT when supply-good is seen high. COUNT moves to READY when the timer expires. Any state returns to OFF when supply-good drops.

A strobe machine (states IDLE, MEASURE, ARMED, SPOILED) qualifies each low period of write-enable:
- IDLE moves to MEASURE, or straight to ARMED when the minimum is one cycle, on a clean low sample.
- MEASURE moves to ARMED once the minimum count of low samples is reached.
- MEASURE returns to IDLE if write-enable rises early.
- IDLE, MEASURE and ARMED all move to SPOILED on an inhibit or blocked sample.
- ARMED returns to IDLE on the rise of write-enable, and issues the write pulse in that cycle.
- SPOILED returns to IDLE once write-enable is high.

Top module: `flash_wr_gate`

## Requirements
- R1: A write-enable low period produces a pulse only if it lasts at least MIN_LOW_CYC sampled cycles. A shorter low period produces no pulse.
- R2: For each qualified low period, `wr_pulse` is high for exactly one clock cycle, in the cycle after the synchronised write-enable is first sampled high again.
- R3: No pulse is produced if any sample of the low period sees chip enable high (`ce_n`=1) or output enable low (`oe_n`=0). This holds even if the strobe returns to the enabled level before write-enable rises.
- R4: While `pwr_good` is 0, `wr_blocked` is 1 in the same cycle, with no clock edge needed, and `wr_pulse` stays 0.
- R5: Suppose `pwr_good` is first sampled as 1 at clock edge k. Then `wr_blocked` stays 1 through edge k+HOLDOFF_CYC-1 and falls to 0 after edge k+HOLDOFF_CYC.
- R6: A drop of `pwr_good` at any time, including after READY, restarts the hold-off. After `pwr_good` returns, the full R5 delay applies again.
- R7: If `wr_blocked` is 1 at any sample of a write-enable low period, that period produces no pulse.
- R8: After reset, `wr_blocked` is 1, `wr_pulse` is 0, and the synchroniser stages hold the inactive (high) level.
- R9: While write-enable stays high, no pulse is produced, whatever chip enable and output enable do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Raw chip enable, active low, asynchronous |
| oe_n | input | 1 | Raw output enable, active low, asynchronous |
| we_n | input | 1 | Raw write enable, active low, asynchronous |
| pwr_good | input | 1 | Supply above sense level, synchronous to clk |
| wr_pulse | output | 1 | One-cycle qualified write pulse to the command sequencer |
| wr_blocked | output | 1 | High while writes are locked out by supply or hold-off |

## Verification
The bench probes the low-width boundary with pulses of one, two, three and four cycles. A counter that is off by one would pass the two-cycle glitch or reject the exact-minimum write. It also bounces chip enable high in the middle of an otherwise long and valid low period. A design that sampled the strobes only at the rising edge of write-enable would then emit a write. It checks the exact edge on which the hold-off ends and restarts it with a supply drop. Writes attempted during hold-off or across a supply drop show whether a design lets a stale, already-armed low period through.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef enum logic [1:0] {
        HO_OFF,
        HO_COUNT,
        HO_READY
    } ho_state_e;

    typedef enum logic [1:0] {
        PW_IDLE,
        PW_MEASURE,
        PW_ARMED,
        PW_SPOILED
    } pw_state_e;

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else if (g == 0) begin
                    stage_q[g] <= d_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/fwg_holdoff.sv
module fwg_holdoff
    import fwg_pkg::*;
#(
    parameter int HOLDOFF_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic blocked
);
    localparam int CNT_W = $clog2(HOLDOFF_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLDOFF_CYC - 1);

    ho_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HO_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HO_OFF: begin
                cnt_d = '0;
                if (pwr_good) state_d = HO_COUNT;
            end
            HO_COUNT: begin
                if (!pwr_good) begin
                    state_d = HO_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = HO_READY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HO_READY: begin
                if (!pwr_good) begin
                    state_d = HO_OFF;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = HO_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        blocked = (state_q != HO_READY) || !pwr_good;
    end
endmodule

// File: rtl/fwg_pulse_fsm.sv
module fwg_pulse_fsm
    import fwg_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_we_n,
    input  logic s_ce_n,
    input  logic s_oe_n,
    input  logic blocked,
    output logic wr_pulse
);
    localparam int RUN_W = $clog2(MIN_LOW_CYC + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_LOW_CYC - 1);

    pw_state_e        state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             clean_low;
    logic             bad_low;

    always_comb begin
        clean_low = !s_we_n && !s_ce_n && s_oe_n && !blocked;
        bad_low   = !s_we_n && !clean_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            PW_IDLE: begin
                run_d = '0;
                if (bad_low) begin
                    state_d = PW_SPOILED;
                end else if (clean_low) begin
                    run_d   = RUN_W'(1);
                    state_d = (MIN_LOW_CYC <= 1) ? PW_ARMED : PW_MEASURE;
                end
            end
            PW_MEASURE: begin
                if (s_we_n) begin
                    state_d = PW_IDLE;
                end else if (bad_low) begin
                    state_d = PW_SPOILED;
                end else if (run_q == RUN_LAST) begin
                    state_d = PW_ARMED;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            PW_ARMED: begin
                if (s_we_n) begin
                    state_d = PW_IDLE;
                end else if (bad_low) begin
                    state_d = PW_SPOILED;
                end
            end
            PW_SPOILED: begin
                if (s_we_n) state_d = PW_IDLE;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = (state_q == PW_ARMED) && s_we_n && !blocked;
    end
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
    parameter int MIN_LOW_CYC = 2,
    parameter int HOLDOFF_CYC = 500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic pwr_good,
    output logic wr_pulse,
    output logic wr_blocked
);
    localparam int STROBES = 3;

    logic [STROBES-1:0] raw_strobes;
    logic [STROBES-1:0] sync_strobes;
    logic               s_ce_n, s_oe_n, s_we_n;

    assign raw_strobes = {ce_n, oe_n, we_n};
    assign {s_ce_n, s_oe_n, s_we_n} = sync_strobes;

    fwg_sync #(
        .WIDTH (STROBES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (raw_strobes),
        .d_out(sync_strobes)
    );

    fwg_holdoff #(
        .HOLDOFF_CYC(HOLDOFF_CYC)
    ) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_good(pwr_good),
        .blocked (wr_blocked)
    );

    fwg_pulse_fsm #(
        .MIN_LOW_CYC(MIN_LOW_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_we_n  (s_we_n),
        .s_ce_n  (s_ce_n),
        .s_oe_n  (s_oe_n),
        .blocked (wr_blocked),
        .wr_pulse(wr_pulse)
    );
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
    parameter int MIN_LOW_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic s_we_n,
    input logic wr_pulse,
    input logic wr_blocked
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (s_we_n) begin
            low_run <= '0;
        end else if (low_run != 16'hFFFF) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R1: a pulse follows a low run of at least the minimum length
    a_r1_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (low_run >= 16'(MIN_LOW_CYC)));

    // R2: the pulse lasts a single cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R2: the pulse appears only when write-enable has just come back high
    a_r2_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (s_we_n && low_run != 16'd0));

    // R4: supply low forces blocked and no pulse
    a_r4_supply_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (wr_blocked && !wr_pulse));

    // R5: a fresh rise of supply-good is followed by a blocked cycle
    a_r5_holdoff_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |=> wr_blocked);

    // R7: no pulse while blocked
    a_r7_blocked_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> !wr_pulse);
endmodule

bind flash_wr_gate fwg_checker #(
    .MIN_LOW_CYC(MIN_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .s_we_n    (s_we_n),
    .wr_pulse  (wr_pulse),
    .wr_blocked(wr_blocked)
);

// File: tb/flash_wr_gate_tb.sv
`timescale 1ns/1ps
module flash_wr_gate_tb;
    localparam int MIN_LOW = 3;
    localparam int HOLD    = 40;
    localparam int NVEC    = 7;

    // vector fields: [11] ce_n, [10] oe_n, [9:2] low length, [1:0] expected pulses
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'd3,  2'd1},   // R1 exact minimum
        {1'b0, 1'b1, 8'd2,  2'd0},   // R1 one short
        {1'b0, 1'b1, 8'd10, 2'd1},   // R2 long write, single pulse
        {1'b1, 1'b1, 8'd5,  2'd0},   // R3 chip enable high
        {1'b0, 1'b0, 8'd5,  2'd0},   // R3 output enable low
        {1'b0, 1'b1, 8'd1,  2'd0},   // R1 glitch
        {1'b0, 1'b1, 8'd4,  2'd1}    // R1 above minimum
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_good = 1'b0;
    logic wr_pulse, wr_blocked;

    int checks = 0;
    int errors = 0;
    int pcount = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_wr_gate #(
        .MIN_LOW_CYC(MIN_LOW),
        .HOLDOFF_CYC(HOLD),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pwr_good(pwr_good), .wr_pulse(wr_pulse), .wr_blocked(wr_blocked)
    );

    always @(negedge clk) if (wr_pulse) pcount++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cycle(logic c, logic o, int len);
        @(negedge clk); ce_n = c; oe_n = o;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_ready();
        @(negedge clk); pwr_good = 1'b1;
        repeat (HOLD + 4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 blocked at reset", int'(wr_blocked), 1);
        check("R8 pulse at reset", int'(wr_pulse), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 blocked after reset", int'(wr_blocked), 1);

        // R7 write while supply low / during hold-off
        pcount = 0;
        write_cycle(1'b0, 1'b1, 6);
        check("R4 write with supply low", pcount, 0);

        // R5 exact hold-off edge
        pwr_good = 1'b1;
        @(posedge clk);
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        check("R5 still blocked at last hold edge", int'(wr_blocked), 1);
        @(negedge clk);
        check("R5 released after hold", int'(wr_blocked), 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            pcount = 0;
            write_cycle(VEC[i][11], VEC[i][10], int'(VEC[i][9:2]));
            check($sformatf("R1/R2/R3 vector %0d", i), pcount, int'(VEC[i][1:0]));
        end

        // R3 chip enable bounces high mid-period
        pcount = 0;
        @(negedge clk); ce_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk); ce_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 chip enable bounce", pcount, 0);

        // R9 write enable held high while strobes toggle
        pcount = 0;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk); oe_n = 1'b1;
        repeat (4) @(negedge clk); ce_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 no write enable", pcount, 0);

        // R4/R6 supply drop mid-write, immediate block
        pcount = 0;
        @(negedge clk); ce_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check("R4 immediate block on drop", int'(wr_blocked), 1);
        @(negedge clk); pwr_good = 1'b1;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk); ce_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 write across supply drop", pcount, 0);
        check("R6 hold-off restarted", int'(wr_blocked), 1);

        // R6 write during restarted hold-off is refused, then accepted later
        pcount = 0;
        write_cycle(1'b0, 1'b1, 5);
        check("R7 write during hold-off", pcount, 0);
        repeat (HOLD) @(negedge clk);
        check("R6 released again", int'(wr_blocked), 0);
        pcount = 0;
        write_cycle(1'b0, 1'b1, 5);
        check("R2 write after restart", pcount, 1);

        // R6 drop after READY
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk);
        check("R6 drop after ready", int'(wr_blocked), 1);
        wait_ready();
        check("R6 ready after second hold", int'(wr_blocked), 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule